// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a cache on its miss path and shortens miss latency for code or data that is read in ascending block order. When the cache reports a miss, the block fetches the missed block from memory. It also fetches the next few block addresses in ascending order. The missed block goes back to the cache. The blocks fetched ahead are held in a small first-in first-out buffer and are never written into the cache. On every later miss only the oldest buffered block is compared with the miss address. A match returns that block without a new memory access and starts one more fetch ahead. A miss that does not match starts a fresh stream.

A cache presents one miss at a time on `miss_valid`/`miss_addr` and waits for the matching `fill_valid`. Memory accepts requests through a valid/ready pair. Memory answers in request order, and every response carries the block address it belongs to. The parameter `BLOCKS_PER_MISS` (2 to 5) sets how many blocks a fresh stream fetches in total, counting the missed block. The same block serves an instruction miss path or a data miss path.

Top module: `sbp_stream_prefetch`

## Requirements
- R1: The buffer holds `BLOCKS_PER_MISS-1` entries, and `BLOCKS_PER_MISS` is limited to 2..5. A fresh stream issues exactly `BLOCKS_PER_MISS` memory requests plus one per later head hit.
- R2: A miss that finds the buffer empty, or whose address differs from the head entry, causes a memory request for the missed address in the cycle after acceptance. Prefetch requests for missed+1 up to missed+`BLOCKS_PER_MISS-1` follow, in ascending order. The fill reports `fill_from_buf`=0.
- R3: Each accepted miss produces exactly one fill, and `fill_addr` equals the accepted miss address. Prefetched blocks are never presented on the fill port on their own.
- R4: A miss that matches the head entry, when that entry's data is already held, gives a fill in the cycle right after acceptance, with `fill_from_buf`=1.
- R5: Every head hit pops the head and adds exactly one prefetch request, for the address one above the newest entry.
- R6: A miss that matches a head entry whose data is still outstanding issues no second request for that block. It fills, with `fill_from_buf`=1, once the tagged response arrives.
- R7: A miss that matches a buffered entry other than the head is handled as a non-matching miss. The buffer is flushed and a new stream starts at the missed address.
- R8: Fill data equals the memory data for the filled address. Responses still in flight for flushed entries are dropped and do not disturb later fills.
- R9: `miss_ready` is low from the cycle after acceptance until the fill cycle. It is also low while a memory request is stalled by `mem_req_ready`=0.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid in the next cycle with the same address.
- R11: While reset is held and right after it, neither a fill nor a memory request is driven, and the buffer is empty, so the first miss goes to memory.
- R12: Block addresses wrap modulo 2^`ADDR_W` when a stream runs past the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | Cache reports a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_ready | output | 1 | Miss accepted when high together with miss_valid |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_addr | input | ADDR_W | Block address tag of the response |
| mem_rsp_data | input | DATA_W | Block data of the response |
| fill_valid | output | 1 | One-cycle block return to the cache |
| fill_addr | output | ADDR_W | Block address of the return |
| fill_data | output | DATA_W | Block data of the return |
| fill_from_buf | output | 1 | 1 when the block came from the buffer |

## Verification
A wrong entry address or a wrong shift shows up at the next head hit. The fill then carries the wrong address or data, or it comes from memory when the buffer should have supplied it. The ascending request stream also gains a gap or a repeat within a few cycles. A lost or stuck valid flag either hangs the cache, with `miss_ready` held low and no fill, or it delays a hit that should have taken one cycle. Responses for flushed entries that get through a bad tag match would corrupt fill data on the next stream. The bench sweeps fresh streams followed by zero to four head hits, with short and long memory latency, with and without request stalls, and with misses issued back to back or after the buffer has settled. It also covers a wrap through address zero, a match on a non-head entry, and a flush while prefetches are still in flight.

// File: rtl/sbp_pkg.sv
// Shared definitions for the stream buffer prefetcher.
// Assumes: nothing beyond the standard language.
package sbp_pkg;

    // Control state of the miss handler.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,  // ready for a miss
        ST_WAIT_DEM  = 2'd1,  // missed block requested from memory
        ST_WAIT_HEAD = 2'd2   // head entry matched, its data still in flight
    } sbp_state_e;

endpackage

// File: rtl/sbp_issue_pick.sv
// Priority picker: returns the lowest index whose bit is set.
// Assumes: N >= 1; idx is meaningful only when any is high.
module sbp_issue_pick #(
    parameter int N     = 3,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     need,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (need[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sbp_tag_cmp.sv
// Compares one key address with every buffer entry tag in parallel.
// Assumes: en masks entries that may not take the key.
module sbp_tag_cmp #(
    parameter int N  = 3,
    parameter int AW = 16
) (
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    input  logic [N-1:0]         en,
    output logic [N-1:0]         hit
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        // One equality comparator per entry.
        assign hit[g] = en[g] && (tags[g] == key);
    end

endmodule

// File: rtl/sbp_stream_prefetch.sv
// Sequential stream buffer prefetcher.
// On a miss that does not match the head entry it flushes the buffer,
// requests the missed block, then requests the following blocks into a
// shift-register FIFO. On a head match it returns the buffered block
// (registered, one cycle) and requests one more block at the tail.
// Assumes: one outstanding miss from the cache at a time; memory answers
// in request order with the block address as tag; responses are always
// taken (no response back-pressure).
module sbp_stream_prefetch
    import sbp_pkg::*;
#(
    parameter int ADDR_W          = 16,
    parameter int DATA_W          = 32,
    parameter int BLOCKS_PER_MISS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_from_buf
);

    localparam int DEPTH = BLOCKS_PER_MISS - 1;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // Buffer entries: index 0 is the head (oldest, lowest address).
    logic [DEPTH-1:0][ADDR_W-1:0] e_addr, n_addr;
    logic [DEPTH-1:0][DATA_W-1:0] e_data, n_data;
    logic [DEPTH-1:0]             e_req,  n_req;
    logic [DEPTH-1:0]             e_vld,  n_vld;
    logic                         live,   n_live;

    sbp_state_e        state;
    logic [ADDR_W-1:0] dem_addr;
    logic              dem_req;

    logic              accept, head_hit, head_ready, start_stream, pop;
    logic              dem_need, dem_done, ent_fire, pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [DEPTH-1:0]  rsp_ent, rsp_en;
    logic [DATA_W-1:0] head_data;

    // Miss handshake: idle and no request held back by memory.
    assign miss_ready = (state == ST_IDLE) && !(mem_req_valid && !mem_req_ready);
    assign accept     = miss_valid && miss_ready;
    assign head_hit   = live && (miss_addr == e_addr[0]);

    // Oldest entry that has not been requested yet.
    sbp_issue_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_pick (
        .need (~e_req & {DEPTH{live}}),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    // Responses are matched by tag to requested entries still waiting.
    assign rsp_en = e_req & ~e_vld & {DEPTH{live && mem_rsp_valid}};

    sbp_tag_cmp #(.N(DEPTH), .AW(ADDR_W)) u_tag (
        .tags (e_addr),
        .key  (mem_rsp_addr),
        .en   (rsp_en),
        .hit  (rsp_ent)
    );

    // Request port: demand block first, then prefetches in order.
    assign dem_need      = (state == ST_WAIT_DEM) && !dem_req;
    assign mem_req_valid = dem_need || pick_any;
    assign mem_req_addr  = dem_need ? dem_addr : e_addr[pick_idx];
    assign ent_fire      = !dem_need && pick_any && mem_req_ready;

    // Head data may come from the entry or from the response this cycle.
    assign head_ready   = e_vld[0] || rsp_ent[0];
    assign head_data    = e_vld[0] ? e_data[0] : mem_rsp_data;
    assign start_stream = accept && !head_hit;
    assign pop          = ((accept && head_hit) || (state == ST_WAIT_HEAD)) && head_ready;
    assign dem_done     = (state == ST_WAIT_DEM) && dem_req && mem_rsp_valid
                          && (mem_rsp_addr == dem_addr);

    // Next buffer contents: mark issue, capture responses, then flush or shift.
    always_comb begin
        n_addr = e_addr;
        n_data = e_data;
        n_req  = e_req;
        n_vld  = e_vld;
        n_live = live;
        if (ent_fire) begin
            n_req[pick_idx] = 1'b1;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (rsp_ent[i]) begin
                n_vld[i]  = 1'b1;
                n_data[i] = mem_rsp_data;
            end
        end
        if (start_stream) begin
            n_live = 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                n_addr[i] = miss_addr + ADDR_W'(i + 1);
                n_req[i]  = 1'b0;
                n_vld[i]  = 1'b0;
            end
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                n_addr[i] = n_addr[i + 1];
                n_data[i] = n_data[i + 1];
                n_req[i]  = n_req[i + 1];
                n_vld[i]  = n_vld[i + 1];
            end
            n_addr[DEPTH-1] = e_addr[DEPTH-1] + ADDR_W'(1);
            n_req[DEPTH-1]  = 1'b0;
            n_vld[DEPTH-1]  = 1'b0;
        end
    end

    // Buffer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_addr <= '0;
            e_data <= '0;
            e_req  <= '0;
            e_vld  <= '0;
            live   <= 1'b0;
        end else begin
            e_addr <= n_addr;
            e_data <= n_data;
            e_req  <= n_req;
            e_vld  <= n_vld;
            live   <= n_live;
        end
    end

    // Miss handler state and demand request bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            dem_addr <= '0;
            dem_req  <= 1'b0;
        end else begin
            if (dem_need && mem_req_ready) begin
                dem_req <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start_stream) begin
                        state    <= ST_WAIT_DEM;
                        dem_addr <= miss_addr;
                        dem_req  <= 1'b0;
                    end else if (accept && !head_ready) begin
                        state <= ST_WAIT_HEAD;
                    end
                end
                ST_WAIT_DEM:  if (dem_done) state <= ST_IDLE;
                ST_WAIT_HEAD: if (pop)      state <= ST_IDLE;
                default:                    state <= ST_IDLE;
            endcase
        end
    end

    // Registered block return to the cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid    <= 1'b0;
            fill_addr     <= '0;
            fill_data     <= '0;
            fill_from_buf <= 1'b0;
        end else begin
            fill_valid <= pop || dem_done;
            if (pop) begin
                fill_addr     <= e_addr[0];
                fill_data     <= head_data;
                fill_from_buf <= 1'b1;
            end else if (dem_done) begin
                fill_addr     <= dem_addr;
                fill_data     <= mem_rsp_data;
                fill_from_buf <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------

    // R1: depth range is legal.
    initial begin
        a_r1_depth_range: assert (BLOCKS_PER_MISS >= 2 && BLOCKS_PER_MISS <= 5)
            else $error("BLOCKS_PER_MISS out of range");
    end

    // Address of the last accepted miss, kept for the fill check.
    logic [ADDR_W-1:0] chk_addr;
    always_ff @(posedge clk) begin
        if (!rst_n)      chk_addr <= '0;
        else if (accept) chk_addr <= miss_addr;
    end

    // R3: every fill belongs to the accepted miss.
    a_r3_fill_addr: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> fill_addr == chk_addr);

    // R4: a held head block returns in the next cycle.
    a_r4_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && head_hit && e_vld[0]) |=>
            (fill_valid && fill_from_buf && fill_data == $past(e_data[0])));

    // R2: the missed block is the first request of a new stream.
    a_r2_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
        start_stream |=> (mem_req_valid && mem_req_addr == $past(miss_addr)));

    // R10: a stalled request is held.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6: no second request for a head block already in flight.
    a_r6_no_dup_head: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_HEAD && e_req[0]) |-> !(mem_req_valid && mem_req_addr == e_addr[0]));

endmodule

// File: tb/sbp_stream_prefetch_bench.sv
// Self-checking bench: sweeps streams of 0..4 head hits over latency,
// stall and timing variants, plus wrap, non-head match and stale flush.
module sbp_stream_prefetch_bench;

    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int BPM = 4;
    localparam int D   = BPM - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b1;
    logic          mem_rsp_valid = 1'b0;
    logic [AW-1:0] mem_rsp_addr = '0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic          fill_from_buf;

    always #2 clk = ~clk;  // 4 ns period

    sbp_stream_prefetch #(.ADDR_W(AW), .DATA_W(DW), .BLOCKS_PER_MISS(BPM)) u_sbp_stream_prefetch (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr), .mem_rsp_data(mem_rsp_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_from_buf(fill_from_buf)
    );

    int n_chk = 0, n_fail = 0, tnow = 0;
    int lat = 3;
    bit stall_en = 1'b0;
    bit done = 1'b0;

    // Memory model queue and request log.
    logic [AW-1:0] q_addr [256];
    int            q_time [256];
    int            q_h = 0, q_t = 0;
    logic [AW-1:0] rlog [4096];
    int            rlog_n = 0;

    // Miss driver and observation.
    bit            drive_miss = 1'b0;
    logic [AW-1:0] drive_addr = '0;
    bit            acc_seen, fill_seen, ready_while_busy;
    int            acc_tick, fill_tick;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] f_data;
    bit            f_buf;

    // Stall hold observation (R10).
    bit            held_prev = 1'b0;
    logic [AW-1:0] held_addr = '0;
    int            hold_bad = 0;

    // Bench stream model.
    bit            m_live = 1'b0;
    logic [AW-1:0] m_head = '0;
    logic [AW-1:0] s_base = '0;
    int            s_mark = 0, s_hits = 0;

    function automatic logic [DW-1:0] blk_data(logic [AW-1:0] a);
        return {a ^ 16'h5A0F, a + 16'h1357};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, observe 1 ns later.
    task automatic tick();
        @(negedge clk);
        tnow++;
        miss_valid    = drive_miss;
        miss_addr     = drive_addr;
        mem_req_ready = !(stall_en && (tnow % 3 == 1));
        mem_rsp_valid = 1'b0;
        if (q_h != q_t && tnow >= q_time[q_h % 256] + lat) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_addr  = q_addr[q_h % 256];
            mem_rsp_data  = blk_data(q_addr[q_h % 256]);
            q_h++;
        end
        #1;
        if (held_prev && !(mem_req_valid && mem_req_addr == held_addr)) hold_bad++;
        held_prev = mem_req_valid && !mem_req_ready;
        held_addr = mem_req_addr;
        if (mem_req_valid && mem_req_ready) begin
            q_addr[q_t % 256] = mem_req_addr;
            q_time[q_t % 256] = tnow;
            q_t++;
            rlog[rlog_n % 4096] = mem_req_addr;
            rlog_n++;
        end
        if (fill_valid) begin
            fill_seen = 1'b1;
            fill_tick = tnow;
            f_addr    = fill_addr;
            f_data    = fill_data;
            f_buf     = fill_from_buf;
        end else if (acc_seen && !fill_seen && miss_ready && tnow > acc_tick) begin
            ready_while_busy = 1'b1;
        end
        if (miss_valid && miss_ready) begin
            drive_miss = 1'b0;
            acc_seen   = 1'b1;
            acc_tick   = tnow;
        end
    endtask

    // Present one miss, wait for its fill, check it against the model.
    task automatic do_miss(logic [AW-1:0] a, bit one_cycle);
        bit exp_buf;
        int guard;
        exp_buf          = m_live && (a == m_head);
        drive_addr       = a;
        drive_miss       = 1'b1;
        acc_seen         = 1'b0;
        fill_seen        = 1'b0;
        ready_while_busy = 1'b0;
        guard            = 0;
        while (!acc_seen && guard < 500) begin tick(); guard++; end
        if (!exp_buf) begin
            s_base = a; s_mark = rlog_n; s_hits = 0; hold_bad = 0;
        end else begin
            s_hits++;
        end
        while (!fill_seen && guard < 1000) begin tick(); guard++; end
        chk(fill_seen, "R3", "fill arrives", fill_seen, 1);
        chk(f_addr == a, "R3", "fill address", f_addr, a);
        chk(f_data == blk_data(a), "R8", "fill data", f_data, blk_data(a));
        chk(f_buf == exp_buf, exp_buf ? "R4" : "R2", "fill source", f_buf, exp_buf);
        chk(!ready_while_busy, "R9", "miss_ready low while busy", ready_while_busy, 0);
        if (exp_buf && one_cycle)
            chk(fill_tick == acc_tick + 1, "R4", "hit latency", fill_tick - acc_tick, 1);
        if (exp_buf && !one_cycle)
            chk(fill_tick > acc_tick, "R6", "pending head fill", fill_tick - acc_tick, 1);
        m_live = 1'b1;
        m_head = a + 1'b1;
    endtask

    // Let the stream settle, then check its whole request sequence.
    task automatic check_stream();
        int bad, cnt;
        repeat (60) tick();
        cnt = rlog_n - s_mark;
        chk(cnt == BPM + s_hits, "R1", "requests in stream", cnt, BPM + s_hits);
        bad = 0;
        for (int i = 0; i < cnt && i < 64; i++)
            if (rlog[(s_mark + i) % 4096] != AW'(s_base + AW'(i))) bad++;
        // R5: each hit extends the ascending sequence by exactly one request.
        chk(bad == 0, (s_hits > 0) ? "R5" : "R2", "ascending request order", bad, 0);
        chk(hold_bad == 0, "R10", "stalled request held", hold_bad, 0);
    endtask

    initial begin
        // R11: reset state.
        repeat (4) tick();
        chk(!fill_valid, "R11", "no fill in reset", fill_valid, 0);
        chk(!mem_req_valid, "R11", "no request in reset", mem_req_valid, 0);
        rst_n = 1'b1;
        tick();
        chk(!fill_valid && !mem_req_valid, "R11", "quiet after reset",
            {fill_valid, mem_req_valid}, 0);

        // Sweep: latency x stall x settle, 0..4 head hits per stream.
        for (int mode = 0; mode < 8; mode++) begin
            lat      = mode[0] ? 11 : 3;
            stall_en = mode[1];
            for (int k = 0; k < 5; k++) begin
                logic [AW-1:0] base;
                base = AW'(16'h0100 + mode * 16'h0100 + k * 16'h0020);
                do_miss(base, 1'b0);
                for (int h = 1; h <= k; h++) begin
                    if (mode[2]) repeat (40) tick();
                    do_miss(base + AW'(h), mode[2]);
                end
                check_stream();
            end
        end

        // R12: stream runs through address zero.
        lat = 3; stall_en = 1'b0;
        do_miss(16'hFFFE, 1'b0);
        for (int h = 1; h <= 4; h++) begin
            repeat (40) tick();
            do_miss(AW'(16'hFFFE + h), 1'b1);
        end
        check_stream();
        chk(rlog[(s_mark + 2) % 4096] == 16'h0000, "R12", "wrapped prefetch address",
            rlog[(s_mark + 2) % 4096], 0);

        // R7: match on a non-head entry starts a new stream.
        do_miss(16'h2000, 1'b0);
        repeat (40) tick();
        do_miss(16'h2002, 1'b0);
        chk(f_buf == 1'b0, "R7", "non-head match served by memory", f_buf, 0);
        check_stream();

        // R8: flush with prefetches still in flight; stale responses dropped.
        lat = 11; stall_en = 1'b1;
        do_miss(16'h3000, 1'b0);
        do_miss(16'h3800, 1'b0);
        do_miss(16'h3801, 1'b0);
        check_stream();
        do_miss(16'h5000, 1'b0);
        do_miss(16'h5002, 1'b0);
        do_miss(16'h5003, 1'b0);
        check_stream();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", tnow);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule